// File: doc/BRIEF.md
# Cache-Index LRU Ordering List

This block tracks how recently each line of a cache has been used. It holds an ordered list of line indices, from the most recently used end to the least recently used end. The least recently used index is always on its output, so a cache controller can read its replacement victim at any time without a request. The list holds only index keys and no tags or data. Its length is fixed by a parameter.

Reset fills the list with every index exactly once, so the output is valid from the first cycle after reset. A cache uses two single-cycle strobes. `insert` moves an index to the most-recently-used end, for example when its line is hit or filled. `free` moves an index to the least-recently-used end, for example when its line is invalidated, so that line is chosen next for replacement. Every slot compares its key with the input key at the same time, and the whole reordering takes one clock edge.

Top module: `lru_index_list`

## Requirements
- R1: The parameter `ELEMENTS` (default 32, at least 2) sets the list length. `key_in` and `lru_key` are max(1, ceil(log2(ELEMENTS))) bits wide.
- R2: After a synchronous reset, slot i holds index i. Slot 0 is the most-recently-used end and slot ELEMENTS-1 is the least-recently-used end, so `lru_key` shows ELEMENTS-1 in the cycle after reset.
- R3: The list always holds every index from 0 to ELEMENTS-1 exactly once. It has no duplicates and no empty slots.
- R4: When `insert` is high with an in-range key, the key moves to slot 0. Entries that were nearer the MRU end than the key's old slot each shift one slot toward the LRU end. All other entries stay in place.
- R5: When `free` is high with an in-range key (and `insert` low), the key moves to the LRU end. Entries that were nearer the LRU end than the key's old slot each shift one slot toward the MRU end. All other entries stay in place.
- R6: When `insert` and `free` are both high in the same cycle, only the insert takes effect.
- R7: Inserting the index already at the MRU end, or freeing the index already at the LRU end, leaves the order unchanged.
- R8: A strobe whose key is ELEMENTS or larger matches no slot and leaves the order unchanged.
- R9: Each operation completes on a single rising edge. Its result is visible on `lru_key` in the cycle after the strobe.
- R10: Reset takes priority over `insert` and `free` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| insert | input | 1 | Move `key_in` to the most-recently-used end |
| free | input | 1 | Move `key_in` to the least-recently-used end |
| key_in | input | KW | Index that the strobe operates on |
| lru_key | output | KW | Current least-recently-used index, taken from a register |

## Verification
Two pairs of functions can fall in the same cycle: insert with free, and reset with either strobe. The bench drives `insert` and `free` high together with a key that sits in the middle of the list. The bench then reads out the whole order and compares it with a model in which only the insert took place. A reset is also applied while `insert` is high, and the bench expects the order that reset alone produces. The random phase draws both strobes on their own, so simultaneous strobes also occur many times against keys in range and out of range.

// File: rtl/lru_list_pkg.sv
package lru_list_pkg;

  // Width of an index key: at least one bit.
  function automatic int key_width(input int elements);
    return (elements > 1) ? $clog2(elements) : 1;
  endfunction

endpackage

// File: rtl/lru_key_match.sv
// Parallel key compare with a running OR from the MRU end.
// seen[i] is high when the key sits in slot 0..i.
module lru_key_match #(
  parameter int ELEMENTS = 32,
  parameter int KW       = lru_list_pkg::key_width(ELEMENTS)
) (
  input  logic [ELEMENTS-1:0][KW-1:0] slots,
  input  logic [KW-1:0]               key,
  output logic [ELEMENTS-1:0]         match,
  output logic [ELEMENTS-1:0]         seen
);

  genvar i;
  generate
    for (i = 0; i < ELEMENTS; i++) begin : g_cmp
      assign match[i] = (slots[i] == key);
      if (i == 0) begin : g_first
        assign seen[i] = match[i];
      end else begin : g_rest
        assign seen[i] = seen[i-1] | match[i];
      end
    end
  endgenerate

endmodule

// File: rtl/lru_slot_reg.sv
// One list slot. The head loads the key on insert, the tail loads it on free.
// Every other slot either holds or takes a neighbour's value.
module lru_slot_reg #(
  parameter int KW      = 5,
  parameter int INIT    = 0,
  parameter bit IS_HEAD = 1'b0,
  parameter bit IS_TAIL = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          do_ins,
  input  logic          do_fre,
  input  logic          shift_ins,
  input  logic          shift_fre,
  input  logic [KW-1:0] key,
  input  logic [KW-1:0] from_mru,
  input  logic [KW-1:0] from_lru,
  output logic [KW-1:0] q
);

  localparam logic [KW-1:0] INIT_V = KW'(INIT);

  logic [KW-1:0] ins_val, fre_val;

  assign ins_val = IS_HEAD ? key : from_mru;
  assign fre_val = IS_TAIL ? key : from_lru;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= INIT_V;
    end else if (do_ins) begin
      if (IS_HEAD || shift_ins) q <= ins_val;
    end else if (do_fre) begin
      if (IS_TAIL || shift_fre) q <= fre_val;
    end
  end

endmodule

// File: rtl/lru_index_list.sv
module lru_index_list #(
  parameter int ELEMENTS = 32,
  parameter int KW       = lru_list_pkg::key_width(ELEMENTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          insert,
  input  logic          free,
  input  logic [KW-1:0] key_in,
  output logic [KW-1:0] lru_key
);

  localparam int LAST = ELEMENTS - 1;

  logic [ELEMENTS-1:0][KW-1:0] slots;
  logic [ELEMENTS-1:0]         match;
  logic [ELEMENTS-1:0]         seen;
  logic                        hit;
  logic                        do_ins, do_fre;

  lru_key_match #(.ELEMENTS(ELEMENTS), .KW(KW)) u_match (
    .slots (slots),
    .key   (key_in),
    .match (match),
    .seen  (seen)
  );

  assign hit    = seen[LAST];
  assign do_ins = insert & hit;
  assign do_fre = free & ~insert & hit;

  genvar i;
  generate
    for (i = 0; i < ELEMENTS; i++) begin : g_slot
      logic [KW-1:0] mru_nb, lru_nb;
      logic          sh_ins, sh_fre;
      if (i == 0) begin : g_head
        assign mru_nb = key_in;
        assign sh_ins = 1'b0;
      end else begin : g_mid_i
        assign mru_nb = slots[i-1];
        assign sh_ins = ~seen[i-1];   // key lies at slot i or further toward the LRU end
      end
      if (i == LAST) begin : g_tail
        assign lru_nb = key_in;
        assign sh_fre = 1'b0;
      end else begin : g_mid_f
        assign lru_nb = slots[i+1];
        assign sh_fre = seen[i];      // key lies at slot i or nearer the MRU end
      end
      lru_slot_reg #(
        .KW(KW), .INIT(i), .IS_HEAD(i == 0), .IS_TAIL(i == LAST)
      ) u_slot (
        .clk       (clk),
        .rst       (rst),
        .do_ins    (do_ins),
        .do_fre    (do_fre),
        .shift_ins (sh_ins),
        .shift_fre (sh_fre),
        .key       (key_in),
        .from_mru  (mru_nb),
        .from_lru  (lru_nb),
        .q         (slots[i])
      );
    end
  endgenerate

  assign lru_key = slots[LAST];

  // R3: no index is held twice
  assert_no_duplicate_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(match));

  // R3: every in-range index is present
  assert_all_present_R3: assert property (@(posedge clk) disable iff (rst)
    (key_in < KW'(ELEMENTS)) |-> hit);

  // R4, R9: an inserted key reaches the MRU slot one edge later
  assert_insert_head_R4: assert property (@(posedge clk) disable iff (rst)
    (insert && hit) |=> slots[0] == $past(key_in));

  // R5, R6, R9: a free without insert puts the key on the output
  assert_free_tail_R5: assert property (@(posedge clk) disable iff (rst)
    (free && !insert && hit) |=> lru_key == $past(key_in));

  // R8: idle cycles and unknown keys leave the order alone
  assert_hold_order_R8: assert property (@(posedge clk) disable iff (rst)
    (!hit || (!insert && !free)) |=> $stable(slots));

endmodule

// File: tb/sim_lru_index_list.sv
module sim_lru_index_list;
  localparam int N  = 12;
  localparam int KW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ins = 1'b0;
  logic          fre = 1'b0;
  logic [KW-1:0] key = '0;
  logic [KW-1:0] lru;

  int  m [N];
  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  lru_index_list #(.ELEMENTS(N)) u0 (
    .clk(clk), .rst(rst), .insert(ins), .free(fre), .key_in(key), .lru_key(lru)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < N; i++) m[i] = i;
  endtask

  task automatic model_op(bit i_, bit f_, int k);
    int p;
    p = -1;
    for (int i = 0; i < N; i++) if (m[i] == k) p = i;
    if (p < 0) return;
    if (i_) begin
      for (int i = p; i > 0; i--) m[i] = m[i-1];
      m[0] = k;
    end else if (f_) begin
      for (int i = p; i < N-1; i++) m[i] = m[i+1];
      m[N-1] = k;
    end
  endtask

  // drive away from the edge, sample one edge later
  task automatic step(bit i_, bit f_, int k, string tag);
    ins = i_; fre = f_; key = k[KW-1:0];
    @(posedge clk); #1;
    model_op(i_, f_, k);
    ins = 1'b0; fre = 1'b0;
    chk(tag, 32'(lru), 32'(m[N-1]));
  endtask

  // Inserting the LRU index N times shows the whole order and restores it.
  task automatic dump(string tag);
    bit seen_k [N];
    int dup;
    dup = 0;
    for (int i = 0; i < N; i++) seen_k[i] = 1'b0;
    for (int j = 0; j < N; j++) begin
      if (seen_k[lru]) dup++;
      seen_k[lru] = 1'b1;
      step(1'b1, 1'b0, int'(lru), tag);
    end
    chk("R3 distinct indices", 32'(dup), 32'd0);
  endtask

  task automatic do_reset(bit with_ins, string tag);
    rst = 1'b1; ins = with_ins; fre = with_ins; key = KW'(3);
    @(posedge clk); #1;
    @(posedge clk); #1;
    rst = 1'b0; ins = 1'b0; fre = 1'b0;
    model_reset();
    chk(tag, 32'(lru), 32'(N-1));
  endtask

  initial begin
    int seed;
    int k;
    bit a, b;
    seed = $urandom(32'h1A2B);
    chk("R1 key width", 32'($bits(lru)), 32'(KW));
    do_reset(1'b0, "R2 reset LRU");
    dump("R2 initial order");

    // R7: MRU insert and LRU free change nothing
    step(1'b1, 1'b0, 0, "R7 insert at MRU");
    step(1'b0, 1'b1, N-1, "R7 free at LRU");
    dump("R7 order unchanged");

    // R4: promote LRU and a middle key
    step(1'b1, 1'b0, N-1, "R4 insert LRU");
    step(1'b1, 1'b0, 5, "R4 insert middle");
    dump("R4 order");

    // R5, R9: free shows on output next cycle
    step(1'b0, 1'b1, 3, "R5 free middle");
    chk("R9 freed key on output", 32'(lru), 32'd3);
    dump("R5 order");

    // R6: both strobes; insert wins
    step(1'b1, 1'b1, 7, "R6 insert over free");
    dump("R6 order");

    // R8: out-of-range keys
    step(1'b1, 1'b0, 13, "R8 insert unknown");
    step(1'b0, 1'b1, 15, "R8 free unknown");
    dump("R8 order");

    // R10: reset with strobes active
    do_reset(1'b1, "R10 reset over strobes");
    dump("R10 order");

    for (int n = 0; n < 3000; n++) begin
      k = int'($urandom_range(15, 0));
      a = 1'($urandom_range(1, 0));
      b = 1'($urandom_range(1, 0));
      step(a, b, k, "R9 random op");
      if (n % 250 == 249) dump("R3 random order");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule